// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block collects up to 64 external interrupt request lines and drives a single interrupt request towards a processor. Each source is configured on its own. It has a two-bit trigger mode: level or edge, with either polarity. It also has a three-bit priority level, and level zero switches the source off. Requests in the edge modes are caught in a per-source latch that stays set until software clears it with an indexed clear write. A global threshold hides every source whose level does not exceed it. A global enable switches the whole controller on or off.

Software reaches the block through a plain synchronous register port. Writes take effect on the clock edge where `wr_en` is high. Reads are combinational from `addr`. A status word tells software which source is currently winning, or that nothing is pending.

A small state machine owns the processor request. It has three states:
- `ST_OFF`: the controller is disabled.
- `ST_IDLE`: the controller is enabled and no source qualifies.
- `ST_ACTIVE`: the controller is enabled and a winner exists.

It moves between them as follows:
- OFF→IDLE and OFF→ACTIVE when the enable bit is set.
- IDLE→ACTIVE when a winner appears.
- ACTIVE→IDLE when the winner disappears.
- IDLE→OFF and ACTIVE→OFF when the enable bit is cleared.

The winning source number is captured in the same edge as the state.

Top module: `prio_irq_ctl`

## Requirements
- R1: The trigger mode of source s sits in the word at address 8 + s/16, bits 2*(s%16)+1 : 2*(s%16), and reads back from there. Code 00 means active-low level, 01 active-high level, 10 falling edge and 11 rising edge.
- R2: The priority level of source s sits in the word at address 16 + s/4, bits 8*(s%4)+2 : 8*(s%4), and reads back from there. Level 0 keeps the source from ever being reported.
- R3: Address 0 bit 0 is the global enable. While it is 0, `irq_o` stays low and the status reports nothing pending.
- R4: Address 1 bits 2:0 hold the threshold, which resets to 0. A source qualifies only when its request is active and its level is strictly greater than the threshold.
- R5: In an edge mode, a qualifying edge sets the source's latch, and the latch holds after the input returns. A write to address 4 + s/32 clears it. For s%32 < 16, the write carries bit 8 set and s%16 in bits 3:0. For s%32 >= 16, it carries bit 24 set and s%16 in bits 19:16. An edge that arrives in the same cycle as the clear keeps the latch set.
- R6: The status word at address 2 has bit 16 set when nothing is pending. Otherwise bit 16 is 0 and bits 5:0 hold the winning source number. All other bits read 0.
- R7: Among qualifying sources, the highest level wins. Ties go to the lowest source number.
- R8: Source 0 is never reported, whatever its configuration and input.
- R9: After reset, every level is 0, every mode is 00, enable and threshold are 0, `irq_o` is low and the status reads 0x0001_0000.
- R10: Request inputs pass through two synchronizing flops. `irq_o` is registered: a level input change driven before clock edge 1 shows on `irq_o` after edge 3 and not after edge 2. `irq_o` is high exactly when the controller is enabled and a winner exists.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_in | input | NUM_SRC | Raw interrupt request lines, asynchronous |
| wr_en | input | 1 | Register write strobe |
| addr | input | AW | Register word address |
| wdata | input | DW | Register write data |
| rdata | output | DW | Register read data (combinational) |
| irq_o | output | 1 | Request to the processor |

## Verification
Every cycle, the assertions check four things:
- a disabled controller raises no request;
- the state machine follows the arbiter, one cycle later, with the same source number;
- the arbiter never names source 0;
- any source the arbiter names has a level above the threshold.

Only the bench scenarios can show the rest:
- the trigger-mode decoding;
- edge latching and its persistence;
- the indexed clear for both halves of a 32-source clear word;
- the clear-versus-new-edge race;
- the exact synchronizer latency;
- tie-breaking among equal levels under random configurations.

// File: rtl/ictl_pkg.sv
package ictl_pkg;
    localparam int ADR_ENABLE = 0;
    localparam int ADR_THRESH = 1;
    localparam int ADR_STATUS = 2;
    localparam int CLR_BASE   = 4;
    localparam int MODE_BASE  = 8;
    localparam int PRI_BASE   = 16;
    localparam int NONE_BIT   = 16;

    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_IDLE   = 2'd1,
        ST_ACTIVE = 2'd2
    } ctl_state_t;
endpackage

// File: rtl/ictl_regs.sv
module ictl_regs #(
    parameter int NUM_SRC = 64,
    parameter int LVL_W   = 3,
    parameter int DW      = 32,
    parameter int AW      = 6
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [AW-1:0]                     addr,
    input  logic [DW-1:0]                     wdata,
    input  logic [DW-1:0]                     stat_word,
    output logic [DW-1:0]                     rdata,
    output logic                              enable,
    output logic [LVL_W-1:0]                  thresh,
    output logic [NUM_SRC-1:0][1:0]           mode,
    output logic [NUM_SRC-1:0][LVL_W-1:0]     level,
    output logic [NUM_SRC-1:0]                clr
);
    import ictl_pkg::*;

    // Write side: every source field decodes its own word address.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enable <= 1'b0;
            thresh <= '0;
            mode   <= '0;
            level  <= '0;
        end else if (wr_en) begin
            if (int'(addr) == ADR_ENABLE) enable <= wdata[0];
            if (int'(addr) == ADR_THRESH) thresh <= wdata[LVL_W-1:0];
            for (int s = 0; s < NUM_SRC; s++) begin
                if (int'(addr) == MODE_BASE + s / 16)
                    mode[s] <= wdata[2*(s%16) +: 2];
                if (int'(addr) == PRI_BASE + s / 4)
                    level[s] <= wdata[8*(s%4) +: LVL_W];
            end
        end
    end

    // Indexed clear strobes: low half of the word for s%32 < 16, high half otherwise.
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_clr
        localparam int HALF = ((s % 32) < 16) ? 0 : 16;
        always_comb begin
            clr[s] = wr_en
                  && (int'(addr) == CLR_BASE + s / 32)
                  && wdata[HALF + 8]
                  && (int'(wdata[HALF +: 4]) == (s % 16));
        end
    end

    // Read side.
    always_comb begin
        rdata = '0;
        if (int'(addr) == ADR_ENABLE) rdata[0] = enable;
        if (int'(addr) == ADR_THRESH) rdata[LVL_W-1:0] = thresh;
        if (int'(addr) == ADR_STATUS) rdata = stat_word;
        for (int s = 0; s < NUM_SRC; s++) begin
            if (int'(addr) == MODE_BASE + s / 16)
                rdata[2*(s%16) +: 2] = mode[s];
            if (int'(addr) == PRI_BASE + s / 4)
                rdata[8*(s%4) +: LVL_W] = level[s];
        end
    end
endmodule

// File: rtl/ictl_src.sv
module ictl_src (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       raw,
    input  logic [1:0] mode,
    input  logic       clr,
    output logic       req
);
    logic sy1_q, sy2_q, prev_q, lat_q;
    logic edge_hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sy1_q  <= 1'b0;
            sy2_q  <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            sy1_q  <= raw;
            sy2_q  <= sy1_q;
            prev_q <= sy2_q;
        end
    end

    // mode[0] selects rising (1) or falling (0) polarity.
    assign edge_hit = mode[0] ? (sy2_q & ~prev_q) : (~sy2_q & prev_q);

    // A new edge outranks a clear in the same cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          lat_q <= 1'b0;
        else if (!mode[1])   lat_q <= 1'b0;
        else if (edge_hit)   lat_q <= 1'b1;
        else if (clr)        lat_q <= 1'b0;
    end

    assign req = mode[1] ? lat_q : (mode[0] ? sy2_q : ~sy2_q);
endmodule

// File: rtl/ictl_arb.sv
module ictl_arb #(
    parameter int NUM_SRC = 64,
    parameter int LVL_W   = 3,
    localparam int ID_W   = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0]            req,
    input  logic [NUM_SRC-1:0][LVL_W-1:0] level,
    input  logic [LVL_W-1:0]              thresh,
    output logic                          valid,
    output logic [ID_W-1:0]               win_id
);
    logic [LVL_W-1:0] best;

    // Source 0 is skipped; strict compare keeps the lowest number on ties.
    always_comb begin
        valid  = 1'b0;
        win_id = '0;
        best   = '0;
        for (int s = 1; s < NUM_SRC; s++) begin
            if (req[s] && (level[s] > thresh) && (!valid || level[s] > best)) begin
                valid  = 1'b1;
                win_id = ID_W'(s);
                best   = level[s];
            end
        end
    end
endmodule

// File: rtl/prio_irq_ctl.sv
module prio_irq_ctl #(
    parameter int NUM_SRC = 64,
    parameter int LVL_W   = 3,
    parameter int DW      = 32,
    parameter int AW      = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] req_in,
    input  logic               wr_en,
    input  logic [AW-1:0]      addr,
    input  logic [DW-1:0]      wdata,
    output logic [DW-1:0]      rdata,
    output logic               irq_o
);
    import ictl_pkg::*;
    localparam int ID_W = $clog2(NUM_SRC);

    logic                          enable;
    logic [LVL_W-1:0]              thresh;
    logic [NUM_SRC-1:0][1:0]       mode;
    logic [NUM_SRC-1:0][LVL_W-1:0] level;
    logic [NUM_SRC-1:0]            clr;
    logic [NUM_SRC-1:0]            src_req;
    logic                          arb_valid;
    logic [ID_W-1:0]               arb_id;
    logic [DW-1:0]                 stat_word;
    ctl_state_t                    state_q, state_d;
    logic [ID_W-1:0]               win_q;

    ictl_regs #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W), .DW(DW), .AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .stat_word(stat_word), .rdata(rdata), .enable(enable), .thresh(thresh),
        .mode(mode), .level(level), .clr(clr)
    );

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        ictl_src u_src (
            .clk(clk), .rst_n(rst_n), .raw(req_in[s]), .mode(mode[s]),
            .clr(clr[s]), .req(src_req[s])
        );
    end

    ictl_arb #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W)) u_arb (
        .req(src_req), .level(level), .thresh(thresh),
        .valid(arb_valid), .win_id(arb_id)
    );

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:    if (enable) state_d = arb_valid ? ST_ACTIVE : ST_IDLE;
            ST_IDLE:   if (!enable) state_d = ST_OFF;
                       else if (arb_valid) state_d = ST_ACTIVE;
            ST_ACTIVE: if (!enable) state_d = ST_OFF;
                       else if (!arb_valid) state_d = ST_IDLE;
            default:   state_d = ST_OFF;
        endcase
    end

    // State register, with the winning number captured alongside.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            win_q   <= '0;
        end else begin
            state_q <= state_d;
            win_q   <= (state_d == ST_ACTIVE) ? arb_id : '0;
        end
    end

    // Outputs decoded from the state.
    always_comb begin
        irq_o               = (state_q == ST_ACTIVE);
        stat_word           = '0;
        stat_word[NONE_BIT] = (state_q != ST_ACTIVE);
        stat_word[ID_W-1:0] = win_q;
    end
endmodule

// File: rtl/ictl_chk.sv
module ictl_chk #(
    parameter int NUM_SRC = 64,
    parameter int LVL_W   = 3,
    localparam int ID_W   = $clog2(NUM_SRC)
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          enable,
    input logic [LVL_W-1:0]              thresh,
    input logic [NUM_SRC-1:0][LVL_W-1:0] level,
    input logic                          arb_valid,
    input logic [ID_W-1:0]               arb_id,
    input logic [ID_W-1:0]               win_q,
    input logic                          irq_o
);
    p_disabled_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !irq_o);

    p_follow_arb_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && arb_valid) |=> (irq_o && win_q == $past(arb_id)));

    p_idle_none_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !arb_valid) |=> (!irq_o && win_q == '0));

    p_no_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        arb_valid |-> (arb_id != '0));

    p_above_thresh_r4: assert property (@(posedge clk) disable iff (!rst_n)
        arb_valid |-> (level[arb_id] > thresh));
endmodule

bind prio_irq_ctl ictl_chk #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .enable(enable), .thresh(thresh), .level(level),
    .arb_valid(arb_valid), .arb_id(arb_id), .win_q(win_q), .irq_o(irq_o)
);

// File: tb/sim_prio_irq_ctl.sv
module sim_prio_irq_ctl;
    localparam int CLK_P = 10;
    localparam int N     = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  req_in = '0;
    logic          wr_en = 1'b0;
    logic [5:0]    addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic          irq_o;

    int n_chk = 0, n_err = 0;
    bit done = 0;

    int unsigned m_lvl [N];
    int unsigned m_mode[N];
    bit          m_lat [N];
    bit [N-1:0]  m_in;
    int unsigned m_thr;
    bit          m_en;

    prio_irq_ctl u0 (.clk(clk), .rst_n(rst_n), .req_in(req_in), .wr_en(wr_en),
                     .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o));

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [31:0] exp_stat();
        bit v = 0; int id = 0; int unsigned best = 0;
        for (int s = 1; s < N; s++) begin
            bit act = (m_mode[s] >= 2) ? m_lat[s] : ((m_mode[s] == 1) ? m_in[s] : !m_in[s]);
            if (m_en && act && m_lvl[s] > m_thr && (!v || m_lvl[s] > best)) begin
                v = 1; id = s; best = m_lvl[s];
            end
        end
        return v ? 32'(id) : 32'h0001_0000;
    endfunction

    task automatic wr(int a, logic [31:0] d);
        @(negedge clk); addr = 6'(a); wdata = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(int a, output logic [31:0] d);
        @(negedge clk); addr = 6'(a); #1; d = rdata;
    endtask

    task automatic settle(); repeat (6) @(negedge clk); endtask

    task automatic put_lvl(int s, int unsigned l);
        logic [31:0] w = '0;
        m_lvl[s] = l;
        for (int j = 0; j < 4; j++) w[8*j +: 3] = 3'(m_lvl[(s/4)*4 + j]);
        wr(16 + s/4, w);
    endtask

    task automatic put_mode(int s, int unsigned m);
        logic [31:0] w = '0;
        m_mode[s] = m;
        if (m < 2) m_lat[s] = 0;
        for (int j = 0; j < 16; j++) w[2*j +: 2] = 2'(m_mode[(s/16)*16 + j]);
        wr(8 + s/16, w);
    endtask

    task automatic put_thr(int unsigned t); m_thr = t; wr(1, 32'(t)); endtask
    task automatic put_en(bit e); m_en = e; wr(0, {31'b0, e}); endtask

    task automatic clr_src(int s);
        m_lat[s] = 0;
        wr(4 + s/32, ((s % 32) < 16) ? (32'h100 | 32'(s % 16))
                                     : (32'h0100_0000 | (32'(s % 16) << 16)));
    endtask

    task automatic drive(bit [N-1:0] v);
        for (int s = 0; s < N; s++) begin
            if (m_mode[s] == 3 && !m_in[s] && v[s]) m_lat[s] = 1;
            if (m_mode[s] == 2 && m_in[s] && !v[s]) m_lat[s] = 1;
        end
        @(negedge clk); m_in = v; req_in = v;
    endtask

    task automatic check_out(string tag);
        logic [31:0] st;
        rd(2, st);
        chk({tag, " status"}, st, exp_stat());
        chk({tag, " irq"}, {31'b0, irq_o}, {31'b0, exp_stat() != 32'h0001_0000});
    endtask

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        bit [N-1:0] v;
        void'($urandom(32'd1234));
        for (int s = 0; s < N; s++) begin m_lvl[s] = 0; m_mode[s] = 0; m_lat[s] = 0; end
        m_in = '0; m_thr = 0; m_en = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9 reset state
        chk("R9 irq", {31'b0, irq_o}, 32'h0);
        rd(2, d);  chk("R9 status", d, 32'h0001_0000);
        rd(0, d);  chk("R9 enable", d, 32'h0);
        rd(1, d);  chk("R9 thresh", d, 32'h0);
        rd(17, d); chk("R9 level word", d, 32'h0);
        rd(9, d);  chk("R9 mode word", d, 32'h0);

        // R1/R2 readback of field positions
        put_mode(21, 1); rd(9, d); chk("R1 mode field", d, 32'h0000_0400);
        put_lvl(6, 5);   rd(17, d); chk("R2 level field", d, 32'h0005_0000);
        put_lvl(6, 0);   put_mode(21, 0);

        // R3 enable gate
        put_mode(5, 1); put_lvl(5, 3); drive(N'(1) << 5); settle();
        check_out("R3 disabled");
        put_en(1); settle(); check_out("R3/R6 enabled");

        // R2 level zero disables
        put_lvl(5, 0); settle(); check_out("R2 level0");
        put_lvl(5, 3);

        // R4 threshold
        put_thr(3); settle(); check_out("R4 equal thr");
        put_thr(2); settle(); check_out("R4 above thr");
        put_thr(0);

        // R10 latency: drive before edge 1, see after edge 3
        drive('0); settle();
        @(negedge clk); req_in[5] = 1'b1; m_in[5] = 1'b1;
        @(negedge clk); @(negedge clk);
        chk("R10 after edge2", {31'b0, irq_o}, 32'h0);
        @(negedge clk);
        chk("R10 after edge3", {31'b0, irq_o}, 32'h1);

        // R7 priority and tie-break
        put_mode(9, 1); put_mode(12, 1); put_mode(40, 1);
        put_lvl(9, 5); put_lvl(12, 5); put_lvl(40, 5);
        drive(m_in | (N'(1) << 9) | (N'(1) << 12) | (N'(1) << 40)); settle();
        check_out("R7 tie lowest");
        put_lvl(40, 6); settle(); check_out("R7 higher wins");
        for (int s = 1; s < N; s++) if (m_lvl[s] != 0) put_lvl(s, 0);

        // R8 source 0 never reported
        put_mode(0, 1); put_lvl(0, 7); drive(N'(1)); settle();
        check_out("R8 source0");

        // R1 active-low level
        put_mode(33, 0); put_lvl(33, 2); drive('0); settle();
        check_out("R1 active low");
        drive(N'(1) << 33); settle(); check_out("R1 low idle");
        put_lvl(33, 0);

        // R5 rising edge, upper half of clear word
        put_mode(20, 3); put_lvl(20, 4);
        drive(N'(1) << 20); settle(); drive('0); settle();
        check_out("R5 rise latched");
        clr_src(20); settle(); check_out("R5 clear upper");

        // R5 falling edge, lower half of clear word, second clear register
        put_mode(35, 2); put_lvl(35, 4);
        drive(N'(1) << 35); settle(); check_out("R5 no fall yet");
        drive('0); settle(); check_out("R5 fall latched");
        clr_src(35); settle(); check_out("R5 clear lower");
        put_lvl(35, 0); put_mode(35, 0);

        // R5 new edge same cycle as clear keeps latch
        drive(N'(1) << 20); settle(); drive('0); settle();
        @(negedge clk); req_in[20] = 1'b1; m_in[20] = 1'b1;
        @(negedge clk);
        wr(4, 32'h0104_0000);
        settle(); check_out("R5 edge beats clear");
        clr_src(20); settle(); check_out("R5 final clear");
        put_lvl(20, 0); put_mode(20, 0);

        // Random: R1 R4 R7
        for (int it = 0; it < 20; it++) begin
            for (int s = 0; s < N; s++) begin
                m_mode[s] = $urandom_range(0, 1);
                m_lvl[s]  = $urandom_range(0, 7);
            end
            for (int r = 0; r < N/16; r++) put_mode(r*16, m_mode[r*16]);
            for (int r = 0; r < N/4; r++) put_lvl(r*4, m_lvl[r*4]);
            put_thr($urandom_range(0, 6));
            v = {$urandom, $urandom};
            drive(v); settle();
            check_out("R7 random");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule